// File: doc/BRIEF.md
# Warp Program-Counter Vote Arbiter

This block holds one program counter per thread of a warp. Each cycle it picks a single master PC from the pool of live thread PCs and presents it as the address for the warp's one shared instruction fetch. It also presents the mask of threads whose own PC equals that master PC. Only those threads take the fetched instruction. On the next clock edge their PCs move to the branch target or to PC+1. Every other thread keeps its PC.

Divergence is handled by the PCs alone: no stack of activity masks is kept. Threads that have gone down a different path wait until the vote picks their PC. The vote is combinational and has four policies:
- the PC shared by the most live threads;
- the lowest live PC;
- the PC of the thread with the deepest call nesting;
- a combined policy: deepest nesting first, then lowest PC.

Threads flagged as finished take no part in the vote. When every thread is finished, the warp retires.

The control is a two-state machine.
- **RUN**: normal voting.
- **RETIRED**: no fetch, empty mask, `warp_done` high.

Transitions:
- **RUN → RETIRED** (retire) at the clock edge where every done flag is set.
- **RETIRED → RUN** (revive) at the clock edge where any done flag is clear.

Top module: `simt_mpc_arbiter`

## Requirements
- R1: After reset every thread PC equals BOOT_PC (default 0) and the state is RUN. With no done flags set, `fetch_pc` is 0, `active_mask` is all ones, `fetch_valid` is 1 and `warp_done` is 0.
- R2: While in RUN, `active_mask` bit i is 1 exactly when thread i is not done and its PC equals `fetch_pc`. `fetch_valid` is 1 when at least one thread is not done.
- R3: At a clock edge, a thread whose mask bit is 1 loads its `br_target` field if its `br_taken` bit is 1, and PC+1 otherwise. A thread whose mask bit is 0 keeps its PC whatever its branch inputs are.
- R4: With policy code 0, the master PC is the value held by the most live threads. A tie goes to the lower PC.
- R5: With policy code 1, the master PC is the lowest live PC.
- R6: With policy code 2, the master PC belongs to the live thread with the largest depth value. A tie goes to the lowest thread index.
- R7: With policy code 3, the master PC belongs to the live thread with the largest depth value. A tie goes to the lowest PC.
- R8: A thread with its done bit set is left out of the vote and the mask, and its PC does not change.
- R9: The cycle after all done bits are seen set, `warp_done` is 1 and both `fetch_valid` and `active_mask` are 0. The cycle after any done bit is seen clear, the block is back in RUN.
- R10: The PC increment wraps modulo 2^PCW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Vote policy: 0 most common, 1 lowest, 2 deepest by index, 3 deepest then lowest PC |
| br_taken | input | NTHR | Per-thread branch taken for the current instruction |
| br_target | input | NTHR*PCW | Per-thread branch target; thread i uses bits [i*PCW +: PCW] |
| depth | input | NTHR*DW | Per-thread call nesting depth; thread i uses bits [i*DW +: DW] |
| done | input | NTHR | Per-thread finished flag |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_pc | output | PCW | Master PC, used as the fetch address |
| active_mask | output | NTHR | Threads that execute the fetched instruction |
| warp_done | output | 1 | All threads finished (RETIRED state) |

## Verification
`fetch_pc`, `active_mask` and `fetch_valid` are combinational from the PC registers and the current inputs. The bench changes inputs just after a falling edge and checks these outputs 1 ns later in the same cycle. PC updates and state changes take effect at the next rising edge, so their effect on the outputs is checked after the following falling edge. `warp_done` is registered and is therefore expected one edge after the done flags change, never in the same cycle.

// File: rtl/simt_pkg.sv
package simt_pkg;
    typedef enum logic [1:0] {
        POL_MAJORITY = 2'd0,
        POL_LOWEST   = 2'd1,
        POL_DEEPEST  = 2'd2,
        POL_DEPTH_PC = 2'd3
    } vote_pol_e;

    typedef enum logic {
        WS_RUN     = 1'b0,
        WS_RETIRED = 1'b1
    } warp_st_e;
endpackage

// File: rtl/simt_pc_file.sv
module simt_pc_file #(
    parameter int NTHR    = 8,
    parameter int PCW     = 16,
    parameter int BOOT_PC = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTHR-1:0]      adv,
    input  logic [NTHR-1:0]      br_taken,
    input  logic [NTHR*PCW-1:0]  br_target,
    output logic [NTHR*PCW-1:0]  pc_flat
);
    localparam logic [PCW-1:0] BOOT = PCW'(BOOT_PC);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [PCW-1:0] pc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_q <= BOOT;
            end else if (adv[t]) begin
                pc_q <= br_taken[t] ? br_target[t*PCW +: PCW] : pc_q + PCW'(1);
            end
        end
        assign pc_flat[t*PCW +: PCW] = pc_q;
    end
endmodule

// File: rtl/simt_pc_vote.sv
module simt_pc_vote
    import simt_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int PCW  = 16,
    parameter int DW   = 4
) (
    input  logic [NTHR*PCW-1:0] pc_flat,
    input  logic [NTHR*DW-1:0]  depth,
    input  logic [NTHR-1:0]     elig,
    input  vote_pol_e           policy,
    output logic [PCW-1:0]      sel_pc,
    output logic                any_elig
);
    localparam int CW = $clog2(NTHR + 1);

    logic [PCW-1:0] pcs  [NTHR];
    logic [DW-1:0]  deps [NTHR];
    logic [CW-1:0]  cnt  [NTHR];
    logic [CW-1:0]  best_cnt;
    logic [DW-1:0]  best_dep;
    logic           take;

    for (genvar t = 0; t < NTHR; t++) begin : g_unpack
        assign pcs[t]  = pc_flat[t*PCW +: PCW];
        assign deps[t] = depth[t*DW +: DW];
    end

    always_comb begin
        for (int i = 0; i < NTHR; i++) begin
            cnt[i] = '0;
            for (int j = 0; j < NTHR; j++) begin
                if (elig[j] && pcs[j] == pcs[i]) cnt[i] = cnt[i] + CW'(1);
            end
        end
        sel_pc   = '0;
        best_cnt = '0;
        best_dep = '0;
        any_elig = 1'b0;
        take     = 1'b0;
        for (int i = 0; i < NTHR; i++) begin
            if (elig[i]) begin
                unique case (policy)
                    POL_MAJORITY: take = (cnt[i] > best_cnt) ||
                                         (cnt[i] == best_cnt && pcs[i] < sel_pc);
                    POL_LOWEST:   take = pcs[i] < sel_pc;
                    POL_DEEPEST:  take = deps[i] > best_dep;
                    POL_DEPTH_PC: take = (deps[i] > best_dep) ||
                                         (deps[i] == best_dep && pcs[i] < sel_pc);
                    default:      take = 1'b0;
                endcase
                if (!any_elig || take) begin
                    sel_pc   = pcs[i];
                    best_cnt = cnt[i];
                    best_dep = deps[i];
                end
                any_elig = 1'b1;
            end
        end
    end
endmodule

// File: rtl/simt_mpc_arbiter.sv
module simt_mpc_arbiter
    import simt_pkg::*;
#(
    parameter int NTHR    = 8,
    parameter int PCW     = 16,
    parameter int DW      = 4,
    parameter int BOOT_PC = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          policy,
    input  logic [NTHR-1:0]     br_taken,
    input  logic [NTHR*PCW-1:0] br_target,
    input  logic [NTHR*DW-1:0]  depth,
    input  logic [NTHR-1:0]     done,
    output logic                fetch_valid,
    output logic [PCW-1:0]      fetch_pc,
    output logic [NTHR-1:0]     active_mask,
    output logic                warp_done
);
    warp_st_e            state_q, state_d;
    logic                all_done;
    logic [NTHR-1:0]     elig;
    logic [NTHR*PCW-1:0] pc_flat;
    logic [PCW-1:0]      sel_pc;
    logic                any_elig;

    assign all_done = &done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_RUN:     if (all_done)  state_d = WS_RETIRED;
            WS_RETIRED: if (!all_done) state_d = WS_RUN;
            default:    state_d = WS_RUN;
        endcase
    end

    always_comb begin
        elig      = '0;
        warp_done = 1'b0;
        unique case (state_q)
            WS_RUN:     elig      = ~done;
            WS_RETIRED: warp_done = 1'b1;
            default:    elig      = '0;
        endcase
    end

    simt_pc_vote #(.NTHR(NTHR), .PCW(PCW), .DW(DW)) u_vote (
        .pc_flat  (pc_flat),
        .depth    (depth),
        .elig     (elig),
        .policy   (vote_pol_e'(policy)),
        .sel_pc   (sel_pc),
        .any_elig (any_elig)
    );

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            active_mask[t] = elig[t] && (pc_flat[t*PCW +: PCW] == sel_pc);
        end
    end

    assign fetch_valid = any_elig;
    assign fetch_pc    = any_elig ? sel_pc : '0;

    simt_pc_file #(.NTHR(NTHR), .PCW(PCW), .BOOT_PC(BOOT_PC)) u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (active_mask),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pc_flat   (pc_flat)
    );
endmodule

// File: rtl/simt_mpc_arbiter_chk.sv
module simt_mpc_arbiter_chk #(
    parameter int NTHR = 8,
    parameter int PCW  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          policy,
    input logic [NTHR-1:0]     br_taken,
    input logic [NTHR-1:0]     done,
    input logic                fetch_valid,
    input logic [PCW-1:0]      fetch_pc,
    input logic [NTHR-1:0]     active_mask,
    input logic                warp_done,
    input logic [NTHR*PCW-1:0] pc_flat
);
    p_fetch_has_thread_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (active_mask != '0));

    p_retired_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warp_done |-> (!fetch_valid && active_mask == '0));

    p_done_excluded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mask & done) == '0);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        p_mask_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
            active_mask[t] |-> (pc_flat[t*PCW +: PCW] == fetch_pc));

        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !active_mask[t] |=> $stable(pc_flat[t*PCW +: PCW]));

        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (active_mask[t] && !br_taken[t]) |=>
            (pc_flat[t*PCW +: PCW] == $past(pc_flat[t*PCW +: PCW]) + PCW'(1)));

        p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (policy == 2'd1 && fetch_valid && !done[t]) |->
            (pc_flat[t*PCW +: PCW] >= fetch_pc));
    end
endmodule

bind simt_mpc_arbiter simt_mpc_arbiter_chk #(.NTHR(NTHR), .PCW(PCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .policy      (policy),
    .br_taken    (br_taken),
    .done        (done),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .active_mask (active_mask),
    .warp_done   (warp_done),
    .pc_flat     (pc_flat)
);

// File: tb/tb_simt_mpc_arbiter.sv
`timescale 1ns/1ps
module tb_simt_mpc_arbiter;
    localparam int NTHR = 8;
    localparam int PCW  = 16;
    localparam int DW   = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          policy = 2'd0;
    logic [NTHR-1:0]     br_taken = '0;
    logic [NTHR*PCW-1:0] br_target = '0;
    logic [NTHR*DW-1:0]  depth = '0;
    logic [NTHR-1:0]     done = '0;
    logic                fetch_valid;
    logic [PCW-1:0]      fetch_pc;
    logic [NTHR-1:0]     active_mask;
    logic                warp_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    simt_mpc_arbiter #(.NTHR(NTHR), .PCW(PCW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .br_taken(br_taken),
        .br_target(br_target), .depth(depth), .done(done),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .active_mask(active_mask), .warp_done(warp_done)
    );

    function automatic logic [NTHR*PCW-1:0] pk_pc(input logic [15:0] a0, a1, a2, a3,
                                                  a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    function automatic logic [NTHR*DW-1:0] pk_dep(input logic [3:0] a0, a1, a2, a3,
                                                  a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic chk(input string req, input logic [PCW-1:0] e_pc,
                       input logic [NTHR-1:0] e_mask, input logic e_valid,
                       input logic e_wd);
        n_checks++;
        if (fetch_pc !== e_pc || active_mask !== e_mask ||
            fetch_valid !== e_valid || warp_done !== e_wd) begin
            n_fail++;
            $display("FAIL %s: pc=%h mask=%b valid=%b wd=%b, expected pc=%h mask=%b valid=%b wd=%b",
                     req, fetch_pc, active_mask, fetch_valid, warp_done,
                     e_pc, e_mask, e_valid, e_wd);
        end
    endtask

    // Inputs change just after a falling edge; outputs are sampled 1 ns later.
    task automatic settle();
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; br_taken = '0; done = '0; policy = 2'd0; depth = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // All threads share PC after reset, so one taken branch loads each target.
    task automatic load_pcs(input logic [NTHR*PCW-1:0] tgt);
        do_reset();
        br_taken = '1; br_target = tgt; policy = 2'd0;
        tick();
        br_taken = '0;
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk("R1 reset state", 16'h0000, 8'hFF, 1'b1, 1'b0);
    endtask

    task automatic t_step_wrap();
        do_reset();
        tick(); settle();
        chk("R3 sequential step", 16'h0001, 8'hFF, 1'b1, 1'b0);
        load_pcs({NTHR{16'hFFFF}}); settle();
        chk("R10 setup at top", 16'hFFFF, 8'hFF, 1'b1, 1'b0);
        tick(); settle();
        chk("R10 wrap to zero", 16'h0000, 8'hFF, 1'b1, 1'b0);
    endtask

    task automatic t_majority();
        load_pcs(pk_pc(10, 20, 20, 30, 30, 30, 5, 5));
        policy = 2'd0; settle();
        chk("R4 majority", 16'd30, 8'h38, 1'b1, 1'b0);
        tick(); settle();
        chk("R4 majority after step", 16'd31, 8'h38, 1'b1, 1'b0);
        load_pcs(pk_pc(10, 10, 20, 20, 7, 9, 40, 40));
        policy = 2'd0; settle();
        chk("R4 tie goes low", 16'd10, 8'h03, 1'b1, 1'b0);
        br_taken = '1; br_target = {NTHR{16'd100}};
        tick(); br_taken = '0;
        policy = 2'd1; settle();
        chk("R3 masked threads hold", 16'd7, 8'h10, 1'b1, 1'b0);
        policy = 2'd0; settle();
        chk("R3 branch target loaded", 16'd20, 8'h0C, 1'b1, 1'b0);
    endtask

    task automatic t_depth();
        load_pcs(pk_pc(50, 12, 80, 12, 33, 90, 12, 33));
        depth = pk_dep(1, 0, 3, 2, 3, 0, 1, 0);
        policy = 2'd1; settle();
        chk("R5 lowest", 16'd12, 8'h4A, 1'b1, 1'b0);
        policy = 2'd2; settle();
        chk("R6 deepest lowest index", 16'd80, 8'h04, 1'b1, 1'b0);
        policy = 2'd3; settle();
        chk("R7 deepest lowest pc", 16'd33, 8'h90, 1'b1, 1'b0);
        policy = 2'd0; settle();
        chk("R4 majority of three", 16'd12, 8'h4A, 1'b1, 1'b0);
    endtask

    task automatic t_done();
        load_pcs(pk_pc(50, 12, 80, 12, 33, 90, 12, 33));
        depth = pk_dep(1, 0, 3, 2, 3, 0, 1, 0);
        done = 8'h4A; policy = 2'd1; settle();
        chk("R8 done excluded", 16'd33, 8'h90, 1'b1, 1'b0);
        br_taken = 8'h4A; br_target = '0;
        tick(); br_taken = '0; done = '0; settle();
        chk("R8 done threads held", 16'd12, 8'h4A, 1'b1, 1'b0);
        policy = 2'd3; done = 8'h80; settle();
        chk("R8 done thread off mask", 16'd34, 8'h10, 1'b1, 1'b0);
    endtask

    task automatic t_retire();
        do_reset();
        done = 8'hFF; settle();
        chk("R9 all done before edge", 16'h0000, 8'h00, 1'b0, 1'b0);
        tick(); settle();
        chk("R9 retired", 16'h0000, 8'h00, 1'b0, 1'b1);
        done = 8'hFE; settle();
        chk("R9 still retired same cycle", 16'h0000, 8'h00, 1'b0, 1'b1);
        tick(); settle();
        chk("R9 revived", 16'h0000, 8'h01, 1'b1, 1'b0);
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_step_wrap();
        t_majority();
        t_depth();
        t_done();
        t_retire();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule